// File: doc/BRIEF.md
# LPC Memory-Write Target Decoder

This block is the target-side front end for memory write cycles on a Low Pin Count bus. Running on the bus clock, it watches the active-low frame signal and the 4-bit multiplexed address/data lines. When a start code arrives and the next nibble marks the cycle as a memory write, it collects a 32-bit address (most significant nibble first) and a data byte (low nibble first).

The host then spends one clock in turnaround. The block takes the bus for one clock, answers with a ready sync, and hands the bus back through two release clocks. When the sync goes out, it raises a single-cycle write strobe and presents the assembled address and byte to the storage logic behind it. It tracks only the host frame and its own phase, so any frame assertion restarts decoding. A cycle type other than memory write is skipped until the next frame.

Top module: `lpc_wr_target`

## Requirements
- R1: While `rst` is high, and in any clock after `dev_sel` was sampled low, `bus_oe` and `wr_stb` are 0 and the cycle is dropped. After reset `wr_addr` and `wr_data` read 0.
- R2: A cycle starts in a clock where `frame_n` is 0 and `bus_in` is 4'b0000. The next clock with `frame_n` 1 is accepted as a memory write when `bus_in[3:1]` is 3'b011; `bus_in[0]` may be 0 or 1.
- R3: The eight nibbles after the type form `wr_addr`, the first nibble landing in bits 31:28 and the last in bits 3:0.
- R4: The two nibbles after the address form `wr_data`, the first in bits 3:0 and the second in bits 7:4 (0x80 arrives as 4'b0000 then 4'b1000).
- R5: In the second clock after the last data nibble (the second turnaround clock), `bus_oe` is 1 and `bus_out` is 4'b1111. A 4'b0000 drive is always preceded by this clock.
- R6: In the clock after that, `bus_oe` is 1, `bus_out` is 4'b0000 (ready), and `wr_stb` is 1 for exactly that clock, with `wr_addr` and `wr_data` holding the values of this cycle.
- R7: `bus_oe` is 0 in the host turnaround clock that follows the data and in the two release clocks after the sync. A new start in the clock after the second release clock is accepted.
- R8: When the type nibble's upper three bits are not 3'b011, no drive and no strobe occur for the rest of that cycle, whatever the later nibbles carry while `frame_n` stays 1.
- R9: `frame_n` at 0 in any clock aborts the cycle in progress with no strobe. If that clock carries 4'b0000 it counts as a new start.
- R10: `wr_addr` and `wr_data` change only in a clock where `wr_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_sel | input | 1 | Device select, active high; low forces idle |
| frame_n | input | 1 | Host frame, active low |
| bus_in | input | 4 | Sampled value of the address/data lines |
| bus_oe | output | 1 | Enable for the block's line driver |
| bus_out | output | 4 | Value to drive when `bus_oe` is 1 |
| wr_stb | output | 1 | One-clock write strobe |
| wr_addr | output | 32 | Address of the last completed write |
| wr_data | output | 8 | Byte of the last completed write |

## Verification
A miscounted nibble counter moves the turnaround drive off its clock. This shows on `bus_oe` in the clock where the 4'b1111 should appear, 13 clocks after the start. A wrong shift direction or wrong entry point shows as a bad `wr_addr` or `wr_data` in the strobe clock itself. A phase register that ignores frame aborts, or a type nibble that is not honoured, shows as a strobe or a driven bus in a cycle that should stay silent. Each check therefore watches the bus enable every clock through the release phase, not only at the strobe.

// File: rtl/lpcw_pkg.sv
`timescale 1ns/1ps
package lpcw_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_TYPE, PH_ADDR, PH_DATA,
    PH_TAR_H, PH_TAR_T, PH_SYNC, PH_REL_A, PH_REL_B
  } phase_t;

  localparam logic [3:0] NIB_START = 4'b0000;
  localparam logic [3:0] NIB_READY = 4'b0000;
  localparam logic [3:0] NIB_OWN   = 4'b1111;
  localparam logic [2:0] TYPE_MEMWR_HI = 3'b011;
endpackage

// File: rtl/lpcw_seq.sv
`timescale 1ns/1ps
module lpcw_seq
  import lpcw_pkg::*;
#(
  parameter int ADDR_NIBS = 8,
  parameter int DATA_NIBS = 2,
  parameter int CNT_W     = 4
) (
  input  logic       clk,
  input  logic       live,
  input  logic       frame_n,
  input  logic [3:0] lad,
  output phase_t     phase_d,
  output logic       cap_addr,
  output logic       cap_data
);
  phase_t             phase_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!live) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (!frame_n) begin
      phase_d = (lad == NIB_START) ? PH_TYPE : PH_IDLE;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_TYPE: begin
          phase_d = (lad[3:1] == TYPE_MEMWR_HI) ? PH_ADDR : PH_IDLE;
          cnt_d   = '0;
        end
        PH_ADDR: begin
          if (cnt_q == CNT_W'(ADDR_NIBS - 1)) begin
            phase_d = PH_DATA;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_DATA: begin
          if (cnt_q == CNT_W'(DATA_NIBS - 1)) begin
            phase_d = PH_TAR_H;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_TAR_H: phase_d = PH_TAR_T;
        PH_TAR_T: phase_d = PH_SYNC;
        PH_SYNC:  phase_d = PH_REL_A;
        PH_REL_A: phase_d = PH_REL_B;
        PH_REL_B: phase_d = PH_IDLE;
        default:  phase_d = PH_IDLE;
      endcase
    end
  end

  assign cap_addr = live && frame_n && (phase_q == PH_ADDR);
  assign cap_data = live && frame_n && (phase_q == PH_DATA);

  always_ff @(posedge clk) begin
    phase_q <= phase_d;
    cnt_q   <= cnt_d;
  end
endmodule

// File: rtl/lpcw_asm.sv
`timescale 1ns/1ps
module lpcw_asm #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIB_W-1:0]  lad,
  input  logic              cap_addr,
  input  logic              cap_data,
  input  logic              commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] data_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_sh <= '0;
      data_sh <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      if (cap_addr) addr_sh <= {addr_sh[ADDR_W-NIB_W-1:0], lad};
      if (cap_data) data_sh <= {lad, data_sh[DATA_W-1:NIB_W]};
      if (commit) begin
        wr_addr <= addr_sh;
        wr_data <= data_sh;
      end
    end
  end
endmodule

// File: rtl/lpcw_pad.sv
`timescale 1ns/1ps
module lpcw_pad
  import lpcw_pkg::*;
(
  input  logic       clk,
  input  logic       live,
  input  phase_t     phase_d,
  output logic       bus_oe,
  output logic [3:0] bus_out,
  output logic       wr_stb
);
  always_ff @(posedge clk) begin
    if (!live) begin
      bus_oe  <= 1'b0;
      bus_out <= NIB_OWN;
      wr_stb  <= 1'b0;
    end else begin
      bus_oe  <= (phase_d == PH_TAR_T) || (phase_d == PH_SYNC);
      bus_out <= (phase_d == PH_SYNC) ? NIB_READY : NIB_OWN;
      wr_stb  <= (phase_d == PH_SYNC);
    end
  end
endmodule

// File: rtl/lpc_wr_target.sv
`timescale 1ns/1ps
module lpc_wr_target
  import lpcw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_sel,
  input  logic              frame_n,
  input  logic [3:0]        bus_in,
  output logic              bus_oe,
  output logic [3:0]        bus_out,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int NIB_W     = 4;
  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int DATA_NIBS = DATA_W / NIB_W;
  localparam int MAX_NIBS  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
  localparam int CNT_W     = $clog2(MAX_NIBS) + 1;

  logic   live;
  phase_t phase_d;
  logic   cap_addr, cap_data, commit;

  assign live   = !rst && dev_sel;
  assign commit = live && (phase_d == PH_SYNC);

  lpcw_seq #(.ADDR_NIBS(ADDR_NIBS), .DATA_NIBS(DATA_NIBS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .live(live), .frame_n(frame_n), .lad(bus_in),
    .phase_d(phase_d), .cap_addr(cap_addr), .cap_data(cap_data)
  );

  lpcw_asm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NIB_W(NIB_W)) u_asm (
    .clk(clk), .rst(rst), .lad(bus_in), .cap_addr(cap_addr),
    .cap_data(cap_data), .commit(commit),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  lpcw_pad u_pad (
    .clk(clk), .live(live), .phase_d(phase_d),
    .bus_oe(bus_oe), .bus_out(bus_out), .wr_stb(wr_stb)
  );
endmodule

// File: rtl/lpcw_chk.sv
`timescale 1ns/1ps
module lpcw_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dev_sel,
  input logic              bus_oe,
  input logic [3:0]        bus_out,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !dev_sel |=> (!bus_oe && !wr_stb)); // R1
  AST_OWN_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> (bus_out == 4'b1111)); // R5
  AST_READY_AFTER_OWN: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && bus_out == 4'b0000) |-> ($past(bus_oe) && $past(bus_out) == 4'b1111)); // R5
  AST_OWN_THEN_READY: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && bus_out == 4'b1111) |=> (!bus_oe || bus_out == 4'b0000)); // R6
  AST_STB_IN_READY: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (bus_oe && bus_out == 4'b0000)); // R6
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb); // R6
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && bus_out == 4'b0000) |=> !bus_oe); // R7
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |-> ($stable(wr_addr) && $stable(wr_data))); // R10
endmodule

bind lpc_wr_target lpcw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .dev_sel(dev_sel), .bus_oe(bus_oe), .bus_out(bus_out),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/tb_lpc_wr_target.sv
`timescale 1ns/1ps
module tb_lpc_wr_target;
  logic        clk = 1'b0;
  logic        rst, dev_sel, frame_n;
  logic [3:0]  host_lad;
  logic [3:0]  bus_in;
  logic        bus_oe, wr_stb;
  logic [3:0]  bus_out;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;

  logic        o_oe, o_stb;
  logic [3:0]  o_out;
  logic [31:0] o_addr;
  logic [7:0]  o_data;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign bus_in = bus_oe ? bus_out : host_lad;

  lpc_wr_target dut (
    .clk(clk), .rst(rst), .dev_sel(dev_sel), .frame_n(frame_n), .bus_in(bus_in),
    .bus_oe(bus_oe), .bus_out(bus_out), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // observe outputs for the coming bus clock, then drive the host side
  task automatic step(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    o_oe = bus_oe; o_stb = wr_stb; o_out = bus_out;
    o_addr = wr_addr; o_data = wr_data;
    frame_n = fr; host_lad = nib;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet(input string tag);
    chk(!o_oe && !o_stb, tag, {o_oe, o_stb}, 0);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [7:0] d, input logic tlo);
    step(1'b0, 4'b0000);
    step(1'b1, {3'b011, tlo});
    for (int i = 7; i >= 0; i--) step(1'b1, a[i*4 +: 4]);
    step(1'b1, d[3:0]);
    step(1'b1, d[7:4]);
    step(1'b1, 4'hF);
    quiet("R7 host turnaround undriven");
    step(1'b1, 4'hF);
    chk(o_oe && o_out == 4'hF && !o_stb, "R5 target turnaround drive", {o_oe, o_stb, o_out}, 6'b10_1111);
    step(1'b1, 4'hF);
    chk(o_oe && o_out == 4'h0 && o_stb, "R6 ready sync with strobe", {o_oe, o_stb, o_out}, 6'b11_0000);
    chk(o_addr == a, "R3 address assembly", o_addr, a);
    chk(o_data == d, "R4 data assembly", o_data, d);
    step(1'b1, 4'hF);
    quiet("R7 first release clock");
    step(1'b1, 4'hF);
    quiet("R7 second release clock");
  endtask

  task automatic t_reset();
    step(1'b1, 4'hF);
    quiet("R1 reset outputs");
    chk(o_addr == 0 && o_data == 0, "R1 reset address/data", {o_addr, o_data}, 0);
  endtask

  task automatic t_basic();
    do_write(32'hFFFF_5555, 8'hAA, 1'b0);      // R2 type low bit 0
    do_write(32'hFFFF_2AAA, 8'h55, 1'b1);      // R2 type low bit 1, back to back R7
    do_write(32'h1234_5678, 8'h80, 1'b0);      // R4 low nibble first
  endtask

  task automatic t_badtype();
    logic [31:0] ha;
    logic [7:0]  hd;
    step(1'b0, 4'b0000);
    step(1'b1, 4'b0100);
    ha = o_addr; hd = o_data;
    for (int i = 0; i < 16; i++) begin
      step(1'b1, (i % 3 == 0) ? 4'b0000 : 4'b0110);
      quiet("R8 ignored cycle type");
    end
    chk(o_addr == ha && o_data == hd, "R10 outputs held after ignored cycle", {o_addr, o_data}, {ha, hd});
  endtask

  task automatic t_abort();
    logic [31:0] ha;
    step(1'b0, 4'b0000);
    step(1'b1, 4'b0110);
    step(1'b1, 4'h1); step(1'b1, 4'h2); step(1'b1, 4'h3);
    do_write(32'hCAFE_0042, 8'h3C, 1'b0);      // R9 restart on start code
    step(1'b0, 4'b0000);
    step(1'b1, 4'b0110);
    for (int i = 0; i < 8; i++) step(1'b1, 4'h9);
    step(1'b1, 4'h7);
    ha = o_addr;
    step(1'b0, 4'h5);                           // R9 abort, not a start
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 4'hF);
      quiet("R9 aborted cycle stays silent");
    end
    chk(o_addr == ha, "R9 no write after abort", o_addr, ha);
  endtask

  task automatic t_desel();
    step(1'b0, 4'b0000);
    step(1'b1, 4'b0110);
    for (int i = 0; i < 8; i++) step(1'b1, 4'hA);
    step(1'b1, 4'h1); step(1'b1, 4'h2);
    step(1'b1, 4'hF);
    dev_sel = 1'b0;
    step(1'b1, 4'hF);
    quiet("R1 deselect drops drive");
    dev_sel = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 4'hF);
      quiet("R1 deselected cycle has no strobe");
    end
    chk(o_addr == 32'hCAFE_0042, "R1 no write on deselect", o_addr, 32'hCAFE_0042);
    do_write(32'h0000_0001, 8'hFE, 1'b1);
  endtask

  initial begin
    rst = 1'b1; dev_sel = 1'b1; frame_n = 1'b1; host_lad = 4'hF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_badtype();
    t_abort();
    t_desel();
    step(1'b1, 4'hF);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule